// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous DRAM interface whose row and column addresses share one bus. All strobe, control and address pins are first brought into a fast system clock domain. The block then watches the order in which the row strobe, the two byte-lane column strobes and the write strobe change. From that order it names the cycle that is under way, and it produces the row index, the column index and the byte-lane controls that an array behind it needs.

When the row strobe falls, the block either captures the row from the address bus or, if a column strobe is already low, takes the row from an internal refresh counter. At each later column-strobe fall it captures the column and records which byte lanes are active. From the level of the write strobe at that moment, or a later fall of the write strobe, it decides between a read, an early write and a read-modify-write. Output enable and the lane strobes gate the per-lane data-drive enables. A column strobe held low during a refresh for long enough moves the cycle into self refresh.

Top module: `dram_cycle_classifier`

## Requirements
- R1: When the synchronised row strobe falls with both column strobes high, row_idx takes the 12-bit address and cycle_kind becomes 4 (row-only refresh). It stays 4 until a column strobe falls.
- R2: When the row strobe falls with either column strobe low, cycle_kind becomes 5 (counter refresh) and row_idx takes the refresh counter value. The address bus is ignored.
- R3: The refresh counter is 0 after reset. It advances by one when the row strobe rises to end a cycle of kind 5 or 6, and it wraps from 4095 to 0.
- R4: On a column-strobe fall while the row strobe is low in a non-refresh cycle, col_idx takes addr[7:0] and lane_en takes the lanes whose strobes are low. Bit 0 is the lower lane (lcas_n) and bit 1 is the upper lane (ucas_n).
- R5: A column-strobe fall with we_n high gives cycle_kind 1 (read). dout_en[i] is high exactly while the row strobe is low, lane i's strobe is low, we_n is high and oe_n is low.
- R6: In a read with oe_n high, both dout_en bits stay 0 (no-operation).
- R7: A column-strobe fall with we_n already low gives cycle_kind 2 (early write) and one wr_strobe pulse with lane_en set to the written lanes. dout_en stays 0 for the rest of the cycle.
- R8: A we_n fall during a read while a lane strobe is low gives cycle_kind 3 (read-modify-write) and one wr_strobe pulse. dout_en is 0 from then on.
- R9: A kind-5 cycle whose column strobe stays low with the row strobe low for SREF_CYCLES clocks becomes cycle_kind 6 (self refresh). dout_en is never set in kinds 4, 5 or 6.
- R10: A rise of the row strobe returns cycle_kind to 0 (idle) and lane_en to 0.
- R11: If a column strobe falls and both column strobes then return high while the row strobe stays high, proto_err pulses once. cycle_kind, col_idx and lane_en are unchanged.
- R12: After reset, cycle_kind, row_idx, col_idx, lane_en, dout_en, wr_strobe and proto_err are all 0.
- R13: Further column-strobe falls in the same row cycle (page mode) capture a new column and lane set, and the cycle kind is decided again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 12 | Multiplexed row/column address |
| row_idx | output | 12 | Selected row |
| col_idx | output | 8 | Selected column |
| lane_en | output | 2 | Active byte lanes of the current access |
| wr_strobe | output | 1 | One-clock write pulse |
| dout_en | output | 2 | Per-lane data drive enable |
| cycle_kind | output | 3 | 0 idle, 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh, 6 self refresh |
| proto_err | output | 1 | One-clock pulse on an abandoned column strobe |

## Verification
Every pin passes through two synchronising flops, so a pin change made between clock edges reaches the synchronised copy at the second rising edge. dout_en follows at that edge. Edge-derived registers (cycle_kind, row_idx, col_idx, lane_en, wr_strobe, proto_err) update one edge later, at the third. The bench drives pins on falling edges, waits four rising edges and samples on the next falling edge, which leaves a margin of one edge for each result. The single-clock pulses wr_strobe and proto_err are counted on every rising edge by a monitor, so they are never sampled at a fixed offset.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;

    localparam int LANES = 2;

    typedef enum logic [2:0] {
        CYC_IDLE     = 3'd0,
        CYC_READ     = 3'd1,
        CYC_EWRITE   = 3'd2,
        CYC_RMW      = 3'd3,
        CYC_RAS_ONLY = 3'd4,
        CYC_CBR      = 3'd5,
        CYC_SELF     = 3'd6
    } cyc_kind_e;

    // synchronised strobe bundle; cas_n[1] is the upper lane
    typedef struct packed {
        logic             ras_n;
        logic [LANES-1:0] cas_n;
        logic             we_n;
        logic             oe_n;
    } strobe_t;

    // row cycle that may still take a column access
    function automatic logic takes_column(cyc_kind_e k);
        return (k == CYC_RAS_ONLY) || (k == CYC_READ) ||
               (k == CYC_EWRITE)   || (k == CYC_RMW);
    endfunction

    function automatic logic drives_data(cyc_kind_e k);
        return (k == CYC_READ) || (k == CYC_RMW);
    endfunction

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dcc_refresh_ctr.sv
module dcc_refresh_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        adv |=> cnt == W'($past(cnt) + 1'b1));
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));
endmodule

// File: rtl/dcc_lane_out.sv
module dcc_lane_out #(
    parameter int LANES = 2
) (
    input  logic             read_phase,
    input  logic [LANES-1:0] cas_low,
    output logic [LANES-1:0] dout_en
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout_en[i] = read_phase & cas_low[i];
    end
endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
    import dram_cyc_pkg::*;
#(
    parameter int ROW_W       = 12,
    parameter int COL_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SREF_CYCLES = 10000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic             lcas_n,
    input  logic             ucas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    output logic [ROW_W-1:0] row_idx,
    output logic [COL_W-1:0] col_idx,
    output logic [LANES-1:0] lane_en,
    output logic             wr_strobe,
    output logic [LANES-1:0] dout_en,
    output logic [2:0]       cycle_kind,
    output logic             proto_err
);
    localparam int SW     = $bits(strobe_t);
    localparam int SREF_W = $clog2(SREF_CYCLES + 1);

    logic [SW-1:0]    strobe_q;
    strobe_t          s;
    logic [ROW_W-1:0] addr_s;

    dcc_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_strobe_sync (
        .clk(clk), .rst(rst),
        .d({ras_n, ucas_n, lcas_n, we_n, oe_n}),
        .q(strobe_q)
    );
    dcc_sync #(.W(ROW_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addr_sync (
        .clk(clk), .rst(rst), .d(addr), .q(addr_s)
    );
    assign s = strobe_t'(strobe_q);

    // one more stage of the strobes for edge detection
    logic             ras_d, we_d;
    logic [LANES-1:0] cas_d;
    always_ff @(posedge clk) begin
        if (rst) begin
            ras_d <= 1'b1;
            cas_d <= '1;
            we_d  <= 1'b1;
        end else begin
            ras_d <= s.ras_n;
            cas_d <= s.cas_n;
            we_d  <= s.we_n;
        end
    end

    logic             ras_fall, ras_rise, ras_low, we_fall;
    logic [LANES-1:0] cas_low, cas_fall;
    assign ras_low  = ~s.ras_n;
    assign ras_fall = ras_d & ~s.ras_n;
    assign ras_rise = ~ras_d & s.ras_n;
    assign we_fall  = we_d & ~s.we_n;
    assign cas_low  = ~s.cas_n;
    assign cas_fall = cas_d & ~s.cas_n;

    cyc_kind_e        kind;
    logic [ROW_W-1:0] rf_cnt;
    logic             rf_adv;
    logic [SREF_W-1:0] sref_cnt;
    logic             cbr_armed;

    assign rf_adv = ras_rise && (kind == CYC_CBR || kind == CYC_SELF);

    dcc_refresh_ctr #(.W(ROW_W)) u_rfsh (
        .clk(clk), .rst(rst), .adv(rf_adv), .cnt(rf_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind      <= CYC_IDLE;
            row_idx   <= '0;
            col_idx   <= '0;
            lane_en   <= '0;
            wr_strobe <= 1'b0;
            proto_err <= 1'b0;
            cbr_armed <= 1'b0;
            sref_cnt  <= '0;
        end else begin
            wr_strobe <= 1'b0;
            proto_err <= 1'b0;
            if (ras_fall) begin
                cbr_armed <= 1'b0;
                sref_cnt  <= '0;
                lane_en   <= '0;
                if (|cas_low) begin
                    kind    <= CYC_CBR;
                    row_idx <= rf_cnt;
                end else begin
                    kind    <= CYC_RAS_ONLY;
                    row_idx <= addr_s;
                end
            end else if (ras_rise) begin
                kind     <= CYC_IDLE;
                lane_en  <= '0;
                sref_cnt <= '0;
            end else if (ras_low) begin
                if (kind == CYC_CBR) begin
                    if (|cas_low) begin
                        if (sref_cnt == SREF_W'(SREF_CYCLES - 1)) kind <= CYC_SELF;
                        else sref_cnt <= sref_cnt + 1'b1;
                    end
                end else if (takes_column(kind)) begin
                    if (|cas_fall) begin
                        col_idx <= addr_s[COL_W-1:0];
                        lane_en <= cas_low;
                        if (!s.we_n) begin
                            kind      <= CYC_EWRITE;
                            wr_strobe <= 1'b1;
                        end else begin
                            kind <= CYC_READ;
                        end
                    end else if (we_fall && kind == CYC_READ && (|cas_low)) begin
                        kind      <= CYC_RMW;
                        wr_strobe <= 1'b1;
                    end
                end
            end else begin
                // row strobe high: a column fall may be the set-up of a counter refresh
                if (|cas_fall) begin
                    cbr_armed <= 1'b1;
                end else if (cbr_armed && !(|cas_low)) begin
                    cbr_armed <= 1'b0;
                    proto_err <= 1'b1;
                end
            end
        end
    end

    logic read_phase;
    assign read_phase = drives_data(kind) & ras_low & s.we_n & ~s.oe_n;

    dcc_lane_out #(.LANES(LANES)) u_lane_out (
        .read_phase(read_phase), .cas_low(cas_low), .dout_en(dout_en)
    );

    assign cycle_kind = kind;

    // counter refresh takes its row from the counter (R2)
    assert_cbr_row_R2: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && (|cas_low)) |=> (kind == CYC_CBR && row_idx == $past(rf_cnt)));
    assert_refresh_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_RAS_ONLY || kind == CYC_CBR || kind == CYC_SELF) |-> dout_en == '0);
    assert_ewrite_hiz_R7: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_EWRITE) |-> dout_en == '0);
    assert_write_kind_R8: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (kind == CYC_EWRITE || kind == CYC_RMW));
    assert_idle_on_rise_R10: assert property (@(posedge clk) disable iff (rst)
        ras_rise |=> (kind == CYC_IDLE && lane_en == '0));
    assert_err_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> (kind == CYC_IDLE && $stable(col_idx)));
endmodule

// File: tb/dram_cycle_classifier_tb.sv
module dram_cycle_classifier_tb;
    localparam int SREF = 50;
    localparam int NV   = 23;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [11:0] addr = '0;
    logic [11:0] row_idx;
    logic [7:0]  col_idx;
    logic [1:0]  lane_en, dout_en;
    logic        wr_strobe, proto_err;
    logic [2:0]  cycle_kind;

    dram_cycle_classifier #(.SREF_CYCLES(SREF)) u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .row_idx(row_idx), .col_idx(col_idx),
        .lane_en(lane_en), .wr_strobe(wr_strobe), .dout_en(dout_en),
        .cycle_kind(cycle_kind), .proto_err(proto_err)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    int wr_cnt = 0, err_cnt = 0;
    logic [1:0] wr_lanes = '0;
    bit done = 0;

    always @(posedge clk) begin
        if (!rst) begin
            if (wr_strobe) begin wr_cnt++; wr_lanes = lane_en; end
            if (proto_err) err_cnt++;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // {ras,lcas,ucas,we,oe}, addr, kind, dout_en, lane_en, row, col
    localparam logic [43:0] VEC [NV] = '{
        {5'b11111, 12'h000, 3'd0, 2'b00, 2'b00, 12'h000, 8'h00},
        {5'b01111, 12'hA5C, 3'd4, 2'b00, 2'b00, 12'hA5C, 8'h00},
        {5'b00010, 12'h03B, 3'd1, 2'b11, 2'b11, 12'hA5C, 8'h3B},
        {5'b00011, 12'h03B, 3'd1, 2'b00, 2'b11, 12'hA5C, 8'h3B},
        {5'b01111, 12'h000, 3'd1, 2'b00, 2'b11, 12'hA5C, 8'h3B},
        {5'b11111, 12'h000, 3'd0, 2'b00, 2'b00, 12'hA5C, 8'h3B},
        {5'b01111, 12'h123, 3'd4, 2'b00, 2'b00, 12'h123, 8'h3B},
        {5'b00110, 12'h045, 3'd1, 2'b01, 2'b01, 12'h123, 8'h45},
        {5'b01110, 12'h000, 3'd1, 2'b00, 2'b01, 12'h123, 8'h45},
        {5'b01010, 12'h046, 3'd1, 2'b10, 2'b10, 12'h123, 8'h46},
        {5'b11111, 12'h000, 3'd0, 2'b00, 2'b00, 12'h123, 8'h46},
        {5'b01101, 12'h200, 3'd4, 2'b00, 2'b00, 12'h200, 8'h46},
        {5'b00001, 12'h011, 3'd2, 2'b00, 2'b11, 12'h200, 8'h11},
        {5'b11111, 12'h000, 3'd0, 2'b00, 2'b00, 12'h200, 8'h11},
        {5'b01110, 12'h300, 3'd4, 2'b00, 2'b00, 12'h300, 8'h11},
        {5'b00110, 12'h022, 3'd1, 2'b01, 2'b01, 12'h300, 8'h22},
        {5'b00100, 12'h022, 3'd3, 2'b00, 2'b01, 12'h300, 8'h22},
        {5'b11111, 12'h000, 3'd0, 2'b00, 2'b00, 12'h300, 8'h22},
        {5'b10011, 12'h000, 3'd0, 2'b00, 2'b00, 12'h300, 8'h22},
        {5'b00011, 12'hFFF, 3'd5, 2'b00, 2'b00, 12'h000, 8'h22},
        {5'b11111, 12'h000, 3'd0, 2'b00, 2'b00, 12'h000, 8'h22},
        {5'b01111, 12'h7FF, 3'd4, 2'b00, 2'b00, 12'h7FF, 8'h22},
        {5'b11111, 12'h000, 3'd0, 2'b00, 2'b00, 12'h7FF, 8'h22}
    };

    function automatic string kind_req(int k);
        case (k)
            0: return "R10";
            1: return "R5";
            2: return "R7";
            3: return "R8";
            4: return "R1";
            5: return "R2";
            default: return "R9";
        endcase
    endfunction

    task automatic cbr_cycle();
        lcas_n = 1'b0; ucas_n = 1'b0;
        step(4);
        ras_n = 1'b0;
        step(4);
        ras_n = 1'b1;
        step(4);
        lcas_n = 1'b1; ucas_n = 1'b1;
        step(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12", "kind", int'(cycle_kind), 0);
        chk("R12", "row", int'(row_idx), 0);
        chk("R12", "col", int'(col_idx), 0);
        chk("R12", "lanes", int'(lane_en), 0);
        chk("R12", "dout", int'(dout_en), 0);
        chk("R12", "wr/err", int'({wr_strobe, proto_err}), 0);

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            v = VEC[i];
            {ras_n, lcas_n, ucas_n, we_n, oe_n} = v[43:39];
            addr = v[38:27];
            step(4);
            chk(kind_req(int'(v[26:24])), $sformatf("kind step %0d", i), int'(cycle_kind), int'(v[26:24]));
            chk((i == 3) ? "R6" : "R5", $sformatf("dout step %0d", i), int'(dout_en), int'(v[23:22]));
            chk("R4", $sformatf("lanes step %0d", i), int'(lane_en), int'(v[21:20]));
            chk((i == 19) ? "R2" : "R1", $sformatf("row step %0d", i), int'(row_idx), int'(v[19:8]));
            chk((i == 9) ? "R13" : "R4", $sformatf("col step %0d", i), int'(col_idx), int'(v[7:0]));
        end
        // R7 and R8 write pulses: one for the early write, one for the read-modify-write
        chk("R7", "write pulses", wr_cnt, 2);
        chk("R8", "last write lanes", int'(wr_lanes), 1);
        chk("R11", "no error in legal traffic", err_cnt, 0);

        // R11 abandoned column strobe while row strobe high
        lcas_n = 1'b0; addr = 12'h0AA;
        step(4);
        lcas_n = 1'b1;
        step(4);
        chk("R11", "error pulses", err_cnt, 1);
        chk("R11", "kind", int'(cycle_kind), 0);
        chk("R11", "col", int'(col_idx), 8'h22);
        chk("R11", "lanes", int'(lane_en), 0);

        // R9 self refresh; counter is 1 after the earlier refresh
        lcas_n = 1'b0;
        step(4);
        ras_n = 1'b0;
        step(20);
        chk("R9", "kind before threshold", int'(cycle_kind), 5);
        chk("R3", "row from counter", int'(row_idx), 1);
        step(60);
        chk("R9", "kind self", int'(cycle_kind), 6);
        chk("R9", "dout in self", int'(dout_en), 0);
        ras_n = 1'b1;
        step(4);
        chk("R9", "kind after exit", int'(cycle_kind), 0);
        lcas_n = 1'b1;
        step(4);

        // R3 wrap: counter is 2 here
        for (int n = 0; n < 4093; n++) cbr_cycle();
        lcas_n = 1'b0;
        step(4);
        ras_n = 1'b0;
        step(4);
        chk("R3", "row at top", int'(row_idx), 12'hFFF);
        ras_n = 1'b1;
        step(4);
        lcas_n = 1'b1;
        step(4);
        ucas_n = 1'b0;
        step(4);
        ras_n = 1'b0;
        step(4);
        chk("R3", "row after wrap", int'(row_idx), 0);
        chk("R2", "kind upper-lane refresh", int'(cycle_kind), 5);
        ras_n = 1'b1;
        step(4);
        ucas_n = 1'b1;
        step(4);
        chk("R11", "no error after refreshes", err_cnt, 1);
        finish_run();
    end
endmodule